// File: doc/BRIEF.md
# Glitch-free Turbo Clock Selector

This block generates the processor clock from a single master oscillator. It can supply either the full master rate (turbo) or half of it (normal speed). The half-rate clock comes from a divide-by-two register. A turbo status flag chooses which of the two clocks reaches the output. At the nominal 6.5 MHz oscillator, the two rates are 6.5 MHz and 3.25 MHz.

Requests arrive as single-cycle pulses, `turbo_on` and `turbo_off`, synchronous to the master clock. A pulse is held until the next safe switching window, so it is never lost. The flag changes only on a falling master edge that happens while the divided clock is low. At that point both candidate clocks are low and stay low until the next rising master edge, where both rise together. As a result, the output never carries a runt pulse or a shortened phase.

Top module: `turbo_clk_sel`

## Requirements
- R1: In normal speed (`turbo`=0) the output clock runs at half the master rate. Each high phase lasts one full master period.
- R2: In turbo (`turbo`=1) the output clock follows the master clock. Each high phase lasts half a master period.
- R3: `turbo` changes only while the output clock is low and the divided clock is low. No high or low phase of the output is ever shorter than half a master period, including phases around a switch.
- R4: When `turbo_on` and `turbo_off` are both high on the same rising master edge, the request resolves to turbo on (flag set to 1).
- R5: A one-cycle `turbo_off` pulse clears `turbo` to 0 within two master cycles after the rising edge that samples it.
- R6: A one-cycle `turbo_on` pulse sets `turbo` to 1 within two master cycles after the rising edge that samples it. A pulse is never lost, whatever the phase of the divided clock. If several requests are sampled before one window, the last one wins.
- R7: With no request present, `turbo` holds its value indefinitely.
- R8: While the synchronous reset is high, the divided clock is held low and `turbo` is cleared to 0, so the output clock is low. Operation starts in normal speed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| turbo_on | input | 1 | Request pulse: switch to full rate |
| turbo_off | input | 1 | Request pulse: switch to half rate |
| cpu_clk | output | 1 | Selected processor clock |
| turbo | output | 1 | Current selection, 1 = full rate |

## Verification
A request pulse is sampled on a rising master edge. It is applied on the first falling edge that finds the divided clock low, which comes either half a cycle or one and a half cycles later. The bench therefore checks the flag two full cycles after the sampling edge, when every phase alignment has settled.

Phase widths are measured continuously from the output's own edges, so that check needs no cycle alignment. A flag change is checked against the output level at the instant it happens. Rate checks time one full high phase against the expected 4 ns or 8 ns.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_ON   = 2'd1,
        REQ_OFF  = 2'd2
    } req_t;

    // Fold new request inputs into a held request: on wins a tie, newest wins otherwise
    function automatic req_t req_merge(input req_t held, input logic on, input logic off);
        if (on)
            return REQ_ON;
        else if (off)
            return REQ_OFF;
        else
            return held;
    endfunction

    function automatic logic req_apply(input req_t r, input logic cur);
        case (r)
            REQ_ON:  return 1'b1;
            REQ_OFF: return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tsel_divider.sv
module tsel_divider (
    input  logic clk,
    input  logic rst,
    output logic div_q
);

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= 1'b0;
        else
            div_q <= ~div_q;
    end

    AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (div_q != $past(div_q))); // R1

endmodule

// File: rtl/tsel_req_latch.sv
module tsel_req_latch
    import tsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic div_q,
    input  logic turbo_on,
    input  logic turbo_off,
    output req_t pend_q
);

    req_t base;

    // A cycle with div_q low ends with its window consumed, so start afresh
    always_comb base = div_q ? pend_q : REQ_NONE;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= REQ_NONE;
        else
            pend_q <= req_merge(base, turbo_on, turbo_off);
    end

    AST_ON_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        turbo_on |=> (pend_q == REQ_ON)); // R4

    AST_OFF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (turbo_off && !turbo_on) |=> (pend_q == REQ_OFF)); // R5

endmodule

// File: rtl/tsel_sel_reg.sv
module tsel_sel_reg
    import tsel_pkg::*;
#(
    parameter logic RST_TURBO = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic div_q,
    input  req_t pend_q,
    output logic sel_q
);

    // Falling master edge with divided clock low: both sources low until next rise
    always_ff @(negedge clk) begin
        if (rst)
            sel_q <= RST_TURBO;
        else if (!div_q)
            sel_q <= req_apply(pend_q, sel_q);
    end

    AST_SWITCH_WHEN_LOW: assert property (@(negedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> ($past(div_q) == 1'b0)); // R3

    AST_HOLD_IDLE: assert property (@(negedge clk) disable iff (rst)
        (pend_q == REQ_NONE) |=> (sel_q == $past(sel_q))); // R7

endmodule

// File: rtl/turbo_clk_sel.sv
module turbo_clk_sel
    import tsel_pkg::*;
#(
    parameter logic RST_TURBO = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic turbo_on,
    input  logic turbo_off,
    output logic cpu_clk,
    output logic turbo
);

    logic div_q;
    logic sel_q;
    req_t pend_q;

    tsel_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .div_q (div_q)
    );

    tsel_req_latch u_req (
        .clk       (clk),
        .rst       (rst),
        .div_q     (div_q),
        .turbo_on  (turbo_on),
        .turbo_off (turbo_off),
        .pend_q    (pend_q)
    );

    tsel_sel_reg #(.RST_TURBO(RST_TURBO)) u_sel (
        .clk    (clk),
        .rst    (rst),
        .div_q  (div_q),
        .pend_q (pend_q),
        .sel_q  (sel_q)
    );

    assign cpu_clk = sel_q ? clk : div_q;
    assign turbo   = sel_q;

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (div_q == 1'b0)); // R8

endmodule

// File: tb/tb_turbo_clk_sel.sv
`timescale 1ns/1ps
module tb_turbo_clk_sel;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic turbo_on = 1'b0;
    logic turbo_off = 1'b0;
    logic cpu_clk;
    logic turbo;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit armed = 0;
    time last_edge = 0;

    turbo_clk_sel dut (
        .clk       (clk),
        .rst       (rst),
        .turbo_on  (turbo_on),
        .turbo_off (turbo_off),
        .cpu_clk   (cpu_clk),
        .turbo     (turbo)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3: every output phase at least half a master period
    always @(cpu_clk) begin
        if (rst) begin
            armed = 0;
        end else if (!armed) begin
            armed = 1;
            last_edge = $time;
        end else begin
            check(($time - last_edge) >= 4, "R3 phase width", $time - last_edge, 4);
            last_edge = $time;
        end
    end

    // R3: flag changes only while the output is low
    always @(turbo) begin
        if (!rst && done == 0)
            check(cpu_clk === 1'b0, "R3 switch while low", cpu_clk, 0);
    end

    task automatic pulse(input logic on, input logic off);
        @(posedge clk); #1;
        turbo_on = on;
        turbo_off = off;
        @(posedge clk); #1;
        turbo_on = 1'b0;
        turbo_off = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic measure_high(input int exp, input string req);
        time t0;
        @(posedge cpu_clk);
        t0 = $time;
        @(negedge cpu_clk);
        check(($time - t0) == exp, req, $time - t0, exp);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1;
        check(cpu_clk === 1'b0, "R8 clk low in reset", cpu_clk, 0);
        check(turbo === 1'b0, "R8 flag clear in reset", turbo, 0);
        rst = 1'b0;
        measure_high(8, "R8 slow after reset");
        check(turbo === 1'b0, "R8 flag after reset", turbo, 0);
    endtask

    task automatic t_on();
        pulse(1'b1, 1'b0);
        settle();
        check(turbo === 1'b1, "R6 on sets flag", turbo, 1);
        measure_high(4, "R2 fast high phase");
    endtask

    task automatic t_off();
        pulse(1'b0, 1'b1);
        settle();
        check(turbo === 1'b0, "R5 off clears flag", turbo, 0);
        measure_high(8, "R1 slow high phase");
    endtask

    task automatic t_both();
        pulse(1'b1, 1'b1);
        settle();
        check(turbo === 1'b1, "R4 on wins tie", turbo, 1);
    endtask

    task automatic t_hold();
        repeat (20) @(posedge clk);
        #1;
        check(turbo === 1'b1, "R7 hold turbo", turbo, 1);
        pulse(1'b0, 1'b1);
        settle();
        repeat (20) @(posedge clk);
        #1;
        check(turbo === 1'b0, "R7 hold normal", turbo, 0);
    endtask

    // R6: pulses on odd alignment are not lost
    task automatic t_phase();
        for (int k = 0; k < 4; k++) begin
            pulse(1'b1, 1'b0);
            settle();
            check(turbo === 1'b1, "R6 on any phase", turbo, 1);
            @(posedge clk);
            pulse(1'b0, 1'b1);
            settle();
            check(turbo === 1'b0, "R5 off any phase", turbo, 0);
        end
    endtask

    task automatic t_random();
        logic exp_flag;
        exp_flag = turbo;
        for (int i = 0; i < 400; i++) begin
            int sel;
            repeat ($urandom_range(0, 4)) @(posedge clk);
            sel = $urandom_range(0, 2);
            if (sel == 0) begin pulse(1'b1, 1'b0); exp_flag = 1'b1; end
            else if (sel == 1) begin pulse(1'b0, 1'b1); exp_flag = 1'b0; end
            else begin pulse(1'b1, 1'b1); exp_flag = 1'b1; end
            if (i % 25 == 0) begin
                settle();
                check(turbo === exp_flag, "R6 random final state", turbo, exp_flag);
            end
        end
        settle();
        check(turbo === exp_flag, "R6 random last request", turbo, exp_flag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired at %0t", $time);
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_on();
        t_off();
        t_both();
        t_hold();
        t_phase();
        t_random();
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule